// File: doc/BRIEF.md
# DRAM Self-Refresh Exit Sequencer

This block sits on the controller side of an asynchronous DRAM and takes the device out of self-refresh before normal accesses start again. While the device is in self-refresh, the sequencer holds both strobes low. When an exit request arrives, it returns RAS# and CAS# high and keeps them high for a fixed exit interval. This interval gives any refresh that the device started internally time to complete.

The exit request carries a refresh-scheme code, and the sequencer captures it. After the exit interval, the next step depends on that code:

- **Distributed CBR:** the controller had been refreshing with distributed CAS-before-RAS cycles, so no catch-up refresh is needed and the sequencer goes straight to ready.
- **Burst CBR or RAS-only:** the sequencer runs a back-to-back refresh of every row, one refresh cycle per row at the minimum cycle time, and only then reports ready.
  - In CBR form, CAS# drops one clock before RAS#.
  - In RAS-only form, CAS# stays high and the row index is driven on the row output for the whole cycle.

The row count, exit interval, refresh cycle length and RAS# low width are parameters counted in clock cycles.

Top module: `sr_exit_seq`

## Requirements
- R1: After reset, ras_n_o and cas_n_o are 1, ready_o is 0 and row_o is 0.
- R2: An enter_i seen at a clock edge while idle or ready puts the block into self-refresh from the next cycle. In self-refresh ras_n_o and cas_n_o are both 0 and ready_o is 0.
- R3: An exit_i seen in self-refresh drives ras_n_o and cas_n_o to 1 from the next cycle. They stay at 1 for T_RPS cycles before any refresh strobe or ready. exit_i has no effect in any other state.
- R4: mode_i is captured in the cycle that exit_i is accepted and is ignored at all other times. The codes are: 2'b00 distributed CBR, 2'b01 burst CBR, 2'b10 RAS-only, and 2'b11 behaves as burst CBR.
- R5: With distributed CBR captured, ready_o rises right after the T_RPS exit cycles, with no refresh strobe in between.
- R6: With any other code captured, exactly ROWS refresh cycles of T_RC clocks each follow the exit cycles back to back, and ready_o rises in the cycle after the last one.
- R7: In a CBR refresh cycle at phase p (0..T_RC-1), cas_n_o is 0 for p < T_RAS and ras_n_o is 0 for 1 <= p <= T_RAS. CAS# therefore always falls one clock before RAS#.
- R8: In a RAS-only refresh cycle, cas_n_o stays 1, ras_n_o follows the same low window as R7, and row_o carries the row index. Row indices run 0 to ROWS-1 in ascending order. row_o is 0 outside the burst.
- R9: enter_i has no effect during the exit interval or the burst refresh.
- R10: ready_o stays 1, with ras_n_o and cas_n_o at 1, until an enter_i is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enter_i | input | 1 | Request to enter self-refresh |
| exit_i | input | 1 | Request to leave self-refresh |
| mode_i | input | 2 | Refresh scheme used before entry, captured on exit |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| row_o | output | ROW_W | Row address during a RAS-only burst, 0 otherwise |
| ready_o | output | 1 | Normal operation may resume |

## Verification
A wrong internal state shows up at the strobes within one clock. A state that is off by one moves ready_o or the first RAS# fall by one cycle, and the per-cycle reference comparison catches that on the very cycle it happens. A wrong captured mode shows up either as CAS# activity during a RAS-only burst or as a burst that is missing or unwanted, visible T_RPS cycles after exit. A fault in the row or phase counters shifts the strobe pattern or row_o within one refresh cycle. A miscount of rows changes the number of RAS# falls, which the bench counts on every run.

// File: rtl/sr_exit_pkg.sv
package sr_exit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SELF  = 3'd1,
    ST_EXIT  = 3'd2,
    ST_BURST = 3'd3,
    ST_READY = 3'd4
  } sr_state_e;

  typedef enum logic [1:0] {
    MODE_DIST      = 2'b00,
    MODE_CBR_BURST = 2'b01,
    MODE_RAS_ONLY  = 2'b10,
    MODE_RSVD      = 2'b11
  } sr_mode_e;

endpackage

// File: rtl/sr_exit_cnt.sv
module sr_exit_cnt #(
  parameter int unsigned W    = 4,
  parameter int unsigned LAST = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == W'(LAST));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/sr_exit_fsm.sv
module sr_exit_fsm
  import sr_exit_pkg::*;
#(
  parameter int unsigned T_RPS = 10,
  localparam int unsigned EW   = (T_RPS > 1) ? $clog2(T_RPS) : 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enter_i,
  input  logic      exit_i,
  input  logic [1:0] mode_i,
  input  logic      burst_done_i,
  output sr_state_e state_o,
  output logic      cbr_o
);

  sr_state_e state_q, state_d;
  sr_mode_e  mode_q;
  logic [EW-1:0] wait_q;
  logic      wait_last;

  assign wait_last = (wait_q == EW'(T_RPS - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_READY: if (enter_i) state_d = ST_SELF;
      ST_SELF:           if (exit_i) state_d = ST_EXIT;
      ST_EXIT:           if (wait_last) state_d = (mode_q == MODE_DIST) ? ST_READY : ST_BURST;
      ST_BURST:          if (burst_done_i) state_d = ST_READY;
      default:           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_DIST;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SELF && exit_i) mode_q <= sr_mode_e'(mode_i);
      // exit interval timer runs only while in ST_EXIT
      if (state_q == ST_EXIT && !wait_last) wait_q <= wait_q + 1'b1;
      else                                  wait_q <= '0;
    end
  end

  assign state_o = state_q;
  assign cbr_o   = (mode_q != MODE_RAS_ONLY);

endmodule

// File: rtl/sr_exit_strobe.sv
module sr_exit_strobe
  import sr_exit_pkg::*;
#(
  parameter int unsigned PH_W  = 3,
  parameter int unsigned T_RAS = 3
) (
  input  sr_state_e       state_i,
  input  logic            cbr_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            ras_n_o,
  output logic            cas_n_o
);

  logic ras_win, cas_win;

  assign ras_win = (phase_i >= PH_W'(1)) && (phase_i <= PH_W'(T_RAS));
  assign cas_win = (phase_i < PH_W'(T_RAS));

  always_comb begin
    ras_n_o = 1'b1;
    cas_n_o = 1'b1;
    unique case (state_i)
      ST_SELF: begin
        ras_n_o = 1'b0;
        cas_n_o = 1'b0;
      end
      ST_BURST: begin
        ras_n_o = !ras_win;
        cas_n_o = !(cbr_i && cas_win);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sr_exit_seq.sv
module sr_exit_seq
  import sr_exit_pkg::*;
#(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned T_RPS = 10,
  parameter int unsigned T_RC  = 6,
  parameter int unsigned T_RAS = 3,
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned PH_W  = (T_RC > 1) ? $clog2(T_RC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic             exit_i,
  input  logic [1:0]       mode_i,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ready_o
);

  sr_state_e        state;
  logic             cbr, in_burst;
  logic [PH_W-1:0]  phase;
  logic [ROW_W-1:0] row;
  logic             phase_last, row_last;

  assign in_burst = (state == ST_BURST);

  sr_exit_fsm #(.T_RPS(T_RPS)) fsm_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_i      (enter_i),
    .exit_i       (exit_i),
    .mode_i       (mode_i),
    .burst_done_i (phase_last && row_last && in_burst),
    .state_o      (state),
    .cbr_o        (cbr)
  );

  sr_exit_cnt #(.W(PH_W), .LAST(T_RC - 1)) phase_cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_burst),
    .en_i   (in_burst),
    .cnt_o  (phase),
    .last_o (phase_last)
  );

  sr_exit_cnt #(.W(ROW_W), .LAST(ROWS - 1)) row_cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_burst),
    .en_i   (in_burst && phase_last),
    .cnt_o  (row),
    .last_o (row_last)
  );

  sr_exit_strobe #(.PH_W(PH_W), .T_RAS(T_RAS)) strobe_i (
    .state_i (state),
    .cbr_i   (cbr),
    .phase_i (phase),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  assign row_o   = in_burst ? row : '0;
  assign ready_o = (state == ST_READY);

endmodule

// File: rtl/sr_exit_seq_chk.sv
module sr_exit_seq_chk
  import sr_exit_pkg::*;
#(
  parameter int unsigned T_RPS = 10,
  parameter int unsigned ROW_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input sr_state_e        state_i,
  input logic             ras_n_i,
  input logic             cas_n_i,
  input logic [ROW_W-1:0] row_i,
  input logic             ready_i
);

  int unsigned hi_cnt;

  // cycles since self-refresh was left, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_cnt <= 0;
    else if (state_i == ST_SELF) hi_cnt <= 0;
    else if (hi_cnt < T_RPS)     hi_cnt <= hi_cnt + 1;
  end

  assert_self_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_SELF |-> !ras_n_i && !cas_n_i && !ready_i);

  assert_exit_time_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BURST || state_i == ST_READY) |-> hi_cnt >= T_RPS);

  assert_cas_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BURST && $fell(ras_n_i) && !cas_n_i) |-> $past(!cas_n_i));

  assert_row_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BURST && $past(state_i == ST_BURST) && row_i != $past(row_i))
      |-> row_i == ROW_W'($past(row_i) + 1'b1));

  assert_no_reentry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXIT || state_i == ST_BURST) |=> state_i != ST_SELF);

  assert_ready_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> ras_n_i && cas_n_i);

endmodule

bind sr_exit_seq sr_exit_seq_chk #(.T_RPS(T_RPS), .ROW_W(ROW_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .state_i (state),
  .ras_n_i (ras_n_o),
  .cas_n_i (cas_n_o),
  .row_i   (row_o),
  .ready_i (ready_o)
);

// File: tb/sr_exit_seq_tb_top.sv
`timescale 1ns/1ps
module sr_exit_seq_tb_top;

  localparam int ROWS  = 16;
  localparam int T_RPS = 10;
  localparam int T_RC  = 6;
  localparam int T_RAS = 3;
  localparam int ROW_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enter_i = 1'b0, exit_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic ras_n_o, cas_n_o, ready_o;
  logic [ROW_W-1:0] row_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sr_exit_seq #(.ROWS(ROWS), .T_RPS(T_RPS), .T_RC(T_RC), .T_RAS(T_RAS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .enter_i(enter_i), .exit_i(exit_i), .mode_i(mode_i),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .row_o(row_o), .ready_o(ready_o));

  // reference model: 0 idle, 1 self, 2 exit wait, 3 burst, 4 ready
  int m_st = 0, m_cnt = 0, m_mode = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st <= 0; m_cnt <= 0; m_mode <= 0;
    end else begin
      case (m_st)
        0, 4: if (enter_i) begin m_st <= 1; m_cnt <= 0; end
        1: if (exit_i) begin m_st <= 2; m_cnt <= 0; m_mode <= int'(mode_i); end
        2: if (m_cnt == T_RPS - 1) begin m_st <= (m_mode == 0) ? 4 : 3; m_cnt <= 0; end
           else m_cnt <= m_cnt + 1;
        3: if (m_cnt == ROWS * T_RC - 1) begin m_st <= 4; m_cnt <= 0; end
           else m_cnt <= m_cnt + 1;
        default: m_st <= 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit e_ras();
    int p;
    if (m_st == 1) return 1'b0;
    if (m_st != 3) return 1'b1;
    p = m_cnt % T_RC;
    return !(p >= 1 && p <= T_RAS);
  endfunction

  function automatic bit e_cas();
    if (m_st == 1) return 1'b0;
    if (m_st != 3 || m_mode == 2) return 1'b1;
    return !((m_cnt % T_RC) < T_RAS);
  endfunction

  function automatic string st_tag();
    case (m_st)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return (m_mode == 2) ? "R8" : "R7";
      default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(ras_n_o == e_ras(), {st_tag(), " ras_n"}, int'(ras_n_o), int'(e_ras()));
      chk(cas_n_o == e_cas(), {st_tag(), " cas_n"}, int'(cas_n_o), int'(e_cas()));
      chk(ready_o == (m_st == 4), "R10 ready", int'(ready_o), int'(m_st == 4));
      chk(int'(row_o) == ((m_st == 3) ? m_cnt / T_RC : 0), "R8 row",
          int'(row_o), (m_st == 3) ? m_cnt / T_RC : 0);
    end
  end

  task automatic run_exit(input logic [1:0] mode, input bit burst);
    int n = 0, falls = 0, exp_n;
    bit prev = 1'b1;
    @(posedge clk); #1 enter_i = 1'b1;
    @(posedge clk); #1 enter_i = 1'b0;
    @(negedge clk);
    chk(!ras_n_o && !cas_n_o, "R2 entry", int'(ras_n_o), 0);
    @(posedge clk); #1 exit_i = 1'b1; mode_i = mode;
    @(posedge clk); #1 exit_i = 1'b0; mode_i = ~mode;  // R4: later mode changes ignored
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (ready_o) break;
      if (prev && !ras_n_o) falls++;
      prev = ras_n_o;
      n++;
      enter_i = (n == 2 || n == T_RPS + 5);  // R9: must be ignored
      exit_i  = (n == 3);                    // R3: ignored outside self-refresh
    end
    enter_i = 1'b0; exit_i = 1'b0;
    exp_n = T_RPS + (burst ? ROWS * T_RC : 0);
    chk(n == exp_n, burst ? "R6 cycles to ready" : "R5 cycles to ready", n, exp_n);
    chk(falls == (burst ? ROWS : 0), burst ? "R6 refresh count" : "R5 refresh count",
        falls, burst ? ROWS : 0);
    repeat (5) @(negedge clk);
    chk(ready_o == 1'b1, "R10 ready held", int'(ready_o), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n_o && cas_n_o, "R1 strobes", int'({ras_n_o, cas_n_o}), 3);
    chk(!ready_o, "R1 ready", int'(ready_o), 0);
    chk(row_o == '0, "R1 row", int'(row_o), 0);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1 exit_i = 1'b1;
    @(posedge clk); #1 exit_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n_o && !ready_o, "R3 exit ignored in idle", int'(ras_n_o), 1);
    run_exit(2'b00, 1'b0);  // R5 distributed
    run_exit(2'b01, 1'b1);  // R7 burst CBR
    run_exit(2'b10, 1'b1);  // R8 RAS-only
    run_exit(2'b11, 1'b1);  // R4 reserved code as burst CBR
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule